// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Core

This block is a synthesizable model of a synchronous SRAM with a shared data bus and a fixed burst length of two. A host issues at most one command per full K period, either a read or a write, each naming one address. Every address holds a pair of words. A write brings its two words in on the two half-cycle edges that follow the command. A read returns its two words on consecutive half-cycle edges after a selectable latency. The latency is either two and a half K periods or one K period.

The model runs on a single clock at twice the K rate. The input `ph` marks the edges that stand for K rising (`ph`=1). The edges in between stand for K# rising (`ph`=0). The model drives the shared data bus only while it presents read words, and it raises `q_vld` for exactly those half-cycles.

Two kinds of command are dropped, and each drop is flagged with `proto_err`. The first is any command on a K# edge. The second is a write whose data phases would land on top of read words that are still due on the bus.

Top module: `ddr2b_sram`

## Requirements
- R1: A command (`cmd_vld`=1) is taken only on an edge with `ph`=1. When `cmd_vld`=1 on a `ph`=0 edge, the command is dropped: a read gives no output and a write changes no stored word. `proto_err` is then high for the one half-cycle after that edge. On any edge with no rejected command, `proto_err` is low in the following half-cycle.
- R2: A write taken on edge W stores the `dq` value present at edge W+1 as word 0 (even sub-address) and the `dq` value at edge W+2 as word 1 (odd sub-address). A later read returns word 0 first and word 1 second.
- R3: With `lat_long`=1, a read taken on edge T drives word 0 on `dq` in the half-cycle after edge T+5 and word 1 in the half-cycle after edge T+6.
- R4: With `lat_long`=0, a read taken on edge T drives word 0 in the half-cycle after edge T+2 and word 1 in the half-cycle after edge T+3.
- R5: `q_vld` is high exactly in the half-cycles that carry read words. At all other times `q_vld` is low and `dq` is released to high impedance.
- R6: Reads taken on every `ph`=1 edge produce an unbroken stream of read words, with `q_vld` held high throughout.
- R7: A read taken on the same edge that captures word 1 of an earlier write to the same address returns both newly written words.
- R8: A read returns the contents as of the edge that takes it. A write to the same address taken later does not alter that read's data.
- R9: A write taken on edge W is dropped if a read was taken on edge W-4 or W-6 (with `lat_long`=1), or on edge W-2 (with `lat_long`=0). A dropped write changes no stored word, and `proto_err` is high for the half-cycle after W.
- R10: While `rst_n` is low, `q_vld` and `proto_err` are low after each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the K rate |
| rst_n | input | 1 | Synchronous active-low reset |
| ph | input | 1 | 1 on edges standing for K rising, 0 on K# rising; alternates every edge |
| lat_long | input | 1 | 1 selects 2.5-period read latency, 0 selects 1-period latency |
| cmd_vld | input | 1 | A command is presented on this edge |
| cmd_wr | input | 1 | 1 for write, 0 for read |
| addr | input | AW | Burst address |
| dq | inout | DW | Shared data bus: write words in, read words out |
| q_vld | output | 1 | High while `dq` carries a read word |
| proto_err | output | 1 | One-half-cycle pulse after a dropped command |

## Verification
The two functions that meet in one cycle are taking a read and capturing the second word of a write. They collide when a read follows a write to the same address by exactly one K period. This is driven both as a directed pair and by random traffic over a 16-entry address space. The bench judges the result by comparing the returned pair with its own image of memory. In that image, captures at an edge are applied before the read at that edge is recorded. The mirror case, where a write trails a read to the same address, is checked to return the old pair.

// File: rtl/ddr2b_pkg.sv
// Shared constants and types for the burst-of-two DDR SRAM model.
// Latencies are counted in half-cycles of K (edges of the 2x clock).
package ddr2b_pkg;
    localparam int LAT_LONG_HALVES  = 5;
    localparam int LAT_SHORT_HALVES = 2;
    localparam int RD_HIST_DEPTH    = LAT_LONG_HALVES + 1;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_WORD0,
        WS_WORD1
    } wr_state_e;
endpackage

// File: rtl/ddr2b_cmd.sv
// Command acceptance and write sequencing.
// Takes commands on ph=1 edges only. It drops K# commands and writes whose
// data phases would overlap pending read output, and pulses proto_err for
// each drop. It then steps a write through its two capture edges.
// Assumes ph alternates on every edge.
module ddr2b_cmd
    import ddr2b_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ph,
    input  logic                     lat_long,
    input  logic                     cmd_vld,
    input  logic                     cmd_wr,
    input  logic [AW-1:0]            addr,
    input  logic [RD_HIST_DEPTH-1:0] rd_hist,
    output logic                     rd_go,
    output logic                     wr_cap0,
    output logic                     wr_cap1,
    output logic [AW-1:0]            wr_addr,
    output logic                     proto_err
);
    localparam int LL = LAT_LONG_HALVES;
    localparam int LS = LAT_SHORT_HALVES;

    wr_state_e wst;
    logic      collide;
    logic      wr_go;
    logic      reject;

    // Read output windows that a write's data phases would overlap
    always_comb begin
        if (lat_long)
            collide = rd_hist[LL-2] | rd_hist[LL-1] | rd_hist[LL];
        else
            collide = rd_hist[LS-2] | rd_hist[LS-1] | rd_hist[LS];
    end

    // Accept / reject decode for the current edge
    always_comb begin
        rd_go  = cmd_vld & ph & ~cmd_wr;
        wr_go  = cmd_vld & ph & cmd_wr & ~collide;
        reject = cmd_vld & (~ph | (cmd_wr & collide));
    end

    // Write burst sequencer: accept -> word0 edge -> word1 edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wst <= WS_IDLE;
        end else begin
            case (wst)
                WS_WORD0: wst <= WS_WORD1;
                default:  wst <= wr_go ? WS_WORD0 : WS_IDLE;
            endcase
        end
    end

    // Hold the address of the write being captured
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_addr <= '0;
        else if (wr_go)
            wr_addr <= addr;
    end

    // One-half-cycle error pulse after a dropped command
    always_ff @(posedge clk) begin
        if (!rst_n)
            proto_err <= 1'b0;
        else
            proto_err <= reject;
    end

    assign wr_cap0 = (wst == WS_WORD0);
    assign wr_cap1 = (wst == WS_WORD1);
endmodule

// File: rtl/ddr2b_store.sv
// Word-pair storage with a forwarding read port.
// Word 0 of each address sits at the even sub-address and word 1 at the odd one.
// The read port returns the contents as of the current edge. When word 1 of
// the same address is captured on this edge, the bus value is forwarded.
// Storage is not reset.
module ddr2b_store #(
    parameter int DW = 18,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          wr_cap0,
    input  logic          wr_cap1,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] din,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_w0,
    output logic [DW-1:0] rd_w1
);
    localparam int WORDS = 2 * (1 << AW);

    logic [DW-1:0] mem [WORDS];
    logic          fwd_hit;

    // Capture one write word per edge into its sub-address
    always_ff @(posedge clk) begin
        if (wr_cap0)
            mem[{wr_addr, 1'b0}] <= din;
        if (wr_cap1)
            mem[{wr_addr, 1'b1}] <= din;
    end

    // Read with forwarding of a word 1 captured on this very edge
    always_comb begin
        fwd_hit = wr_cap1 && (wr_addr == rd_addr);
        rd_w0   = mem[{rd_addr, 1'b0}];
        rd_w1   = fwd_hit ? din : mem[{rd_addr, 1'b1}];
    end
endmodule

// File: rtl/ddr2b_rdpipe.sv
// Read latency pipeline and output register.
// Carries each read's word pair for up to RD_HIST_DEPTH edges. It loads word 0
// and then word 1 into the output register at the selected latency.
// Assumes lat_long changes only while no read is in flight.
module ddr2b_rdpipe
    import ddr2b_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lat_long,
    input  logic                     rd_go,
    input  logic [DW-1:0]            rd_w0,
    input  logic [DW-1:0]            rd_w1,
    output logic [RD_HIST_DEPTH-1:0] rd_hist,
    output logic [DW-1:0]            q_out,
    output logic                     q_oe
);
    localparam int LL = LAT_LONG_HALVES;
    localparam int LS = LAT_SHORT_HALVES;

    logic [RD_HIST_DEPTH-1:0] stg_v;
    logic [2*DW-1:0]          stg_d [RD_HIST_DEPTH];
    logic                     w0_take;
    logic                     w1_take;
    logic [DW-1:0]            w0_src;
    logic [DW-1:0]            w1_src;

    // Valid bits: one per edge since a read was taken
    always_ff @(posedge clk) begin
        if (!rst_n)
            stg_v <= '0;
        else
            stg_v <= {stg_v[RD_HIST_DEPTH-2:0], rd_go};
    end

    // Data pairs travel with their valid bits
    always_ff @(posedge clk) begin
        stg_d[0] <= {rd_w1, rd_w0};
        for (int i = 1; i < RD_HIST_DEPTH; i++)
            stg_d[i] <= stg_d[i-1];
    end

    // Pick the taps for the selected latency
    always_comb begin
        if (lat_long) begin
            w0_take = stg_v[LL-1];
            w1_take = stg_v[LL];
            w0_src  = stg_d[LL-1][DW-1:0];
            w1_src  = stg_d[LL][2*DW-1:DW];
        end else begin
            w0_take = stg_v[LS-1];
            w1_take = stg_v[LS];
            w0_src  = stg_d[LS-1][DW-1:0];
            w1_src  = stg_d[LS][2*DW-1:DW];
        end
    end

    // Output register and bus enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_out <= '0;
            q_oe  <= 1'b0;
        end else begin
            q_oe <= w0_take | w1_take;
            if (w0_take)
                q_out <= w0_src;
            else if (w1_take)
                q_out <= w1_src;
        end
    end

    assign rd_hist = stg_v;
endmodule

// File: rtl/ddr2b_sram.sv
// Top of the burst-of-two DDR SRAM model.
// Ties command handling, storage and the read pipeline to one shared data bus.
// The bus is driven only while read words are presented.
// Runs on a 2x clock; ph=1 marks K-rising edges.
module ddr2b_sram
    import ddr2b_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ph,
    input  logic          lat_long,
    input  logic          cmd_vld,
    input  logic          cmd_wr,
    input  logic [AW-1:0] addr,
    inout  wire  [DW-1:0] dq,
    output logic          q_vld,
    output logic          proto_err
);
    logic [RD_HIST_DEPTH-1:0] rd_hist;
    logic                     rd_go;
    logic                     wr_cap0;
    logic                     wr_cap1;
    logic [AW-1:0]            wr_addr;
    logic [DW-1:0]            rd_w0;
    logic [DW-1:0]            rd_w1;
    logic [DW-1:0]            q_out;
    logic                     q_oe;

    ddr2b_cmd #(.AW(AW)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph        (ph),
        .lat_long  (lat_long),
        .cmd_vld   (cmd_vld),
        .cmd_wr    (cmd_wr),
        .addr      (addr),
        .rd_hist   (rd_hist),
        .rd_go     (rd_go),
        .wr_cap0   (wr_cap0),
        .wr_cap1   (wr_cap1),
        .wr_addr   (wr_addr),
        .proto_err (proto_err)
    );

    ddr2b_store #(.DW(DW), .AW(AW)) u_store (
        .clk     (clk),
        .wr_cap0 (wr_cap0),
        .wr_cap1 (wr_cap1),
        .wr_addr (wr_addr),
        .din     (dq),
        .rd_addr (addr),
        .rd_w0   (rd_w0),
        .rd_w1   (rd_w1)
    );

    ddr2b_rdpipe #(.DW(DW)) u_rdpipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .lat_long (lat_long),
        .rd_go    (rd_go),
        .rd_w0    (rd_w0),
        .rd_w1    (rd_w1),
        .rd_hist  (rd_hist),
        .q_out    (q_out),
        .q_oe     (q_oe)
    );

    // Drive the shared bus only during read word half-cycles
    assign dq    = q_oe ? q_out : {DW{1'bz}};
    assign q_vld = q_oe;
endmodule

// File: rtl/ddr2b_sram_chk.sv
// Port-level protocol checker for ddr2b_sram, attached by bind.
// It derives taken reads from the command ports and relates them to q_vld
// and proto_err over time.
module ddr2b_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic ph,
    input logic lat_long,
    input logic cmd_vld,
    input logic cmd_wr,
    input logic q_vld,
    input logic proto_err
);
    logic rd_acc;
    assign rd_acc = cmd_vld && !cmd_wr && ph;

    // R1: a command on a K# edge is flagged
    p_off_phase_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld && !ph |=> proto_err);

    // R1: the flag only ever follows a presented command
    p_err_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(cmd_vld));

    // R3: long latency places two valid half-cycles after five edges
    p_long_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lat_long && rd_acc |-> ##6 q_vld ##1 q_vld);

    // R4: short latency places two valid half-cycles after two edges
    p_short_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_long && rd_acc |-> ##3 q_vld ##1 q_vld);

    // R5: valid only when some read is due at this point
    p_vld_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q_vld |-> (lat_long ? ($past(rd_acc, 6) || $past(rd_acc, 7))
                            : ($past(rd_acc, 3) || $past(rd_acc, 4))));

    // R9: a write overlapping pending read output is flagged
    p_wr_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ph && cmd_vld && cmd_wr &&
        (lat_long ? ($past(rd_acc, 4) || $past(rd_acc, 6)) : $past(rd_acc, 2))
        |=> proto_err);
endmodule

bind ddr2b_sram ddr2b_sram_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph        (ph),
    .lat_long  (lat_long),
    .cmd_vld   (cmd_vld),
    .cmd_wr    (cmd_wr),
    .q_vld     (q_vld),
    .proto_err (proto_err)
);

// File: tb/tb_ddr2b_sram.sv
module tb_ddr2b_sram;
    localparam int DW    = 18;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int RING  = 16;

    logic          clk      = 1'b0;
    logic          rst_n    = 1'b0;
    logic          ph       = 1'b0;
    logic          lat_long = 1'b1;
    logic          cmd_vld  = 1'b0;
    logic          cmd_wr   = 1'b0;
    logic [AW-1:0] addr     = '0;
    logic          tb_oe    = 1'b0;
    logic [DW-1:0] tb_d     = '0;
    wire  [DW-1:0] dq;
    logic          q_vld;
    logic          proto_err;

    assign dq = tb_oe ? tb_d : {DW{1'bz}};

    always #4 clk = ~clk;

    ddr2b_sram #(.DW(DW), .AW(AW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph        (ph),
        .lat_long  (lat_long),
        .cmd_vld   (cmd_vld),
        .cmd_wr    (cmd_wr),
        .addr      (addr),
        .dq        (dq),
        .q_vld     (q_vld),
        .proto_err (proto_err)
    );

    int  checks = 0;
    int  errors = 0;
    int  e      = 0;
    bit  done   = 0;

    logic [DW-1:0] ref_mem [2*DEPTH];
    bit            x_vld [RING];
    logic [DW-1:0] x_q   [RING];
    string         x_tag [RING];
    bit            x_err [RING];
    string         x_etag[RING];
    bit            d_en  [RING];
    bit            d_cap [RING];
    logic [DW-1:0] d_val [RING];
    int            d_idx [RING];
    bit            rd_at [RING];

    function automatic int lat_halves(bit lng);
        return lng ? 5 : 2;
    endfunction

    function automatic bit wr_blocked(int edge_n, bit lng);
        if (lng)
            return rd_at[(edge_n + RING - 4) % RING] || rd_at[(edge_n + RING - 6) % RING];
        return rd_at[(edge_n + RING - 2) % RING];
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at edge %0d: actual %0h expected %0h", tag, what, e, act, exp);
        end
    endtask

    // Prepare edge e, advance across it, then check what follows it
    task automatic edge_cmd(bit v, bit w, logic [AW-1:0] a, string tag);
        int    s;
        bit    k;
        int    lat;
        int    s0;
        int    s1;
        string rtag;
        s  = e % RING;
        k  = (e % 2 == 0);
        ph      = k;
        cmd_vld = v;
        cmd_wr  = w;
        addr    = a;
        tb_oe   = d_en[s];
        tb_d    = d_val[s];
        if (d_cap[s])
            ref_mem[d_idx[s]] = d_val[s];
        rd_at[s] = v && k && !w && rst_n;
        x_etag[s] = rst_n ? "R1" : "R10";
        if (v && !k) begin
            x_err[s] = 1'b1;
        end else if (v && w && wr_blocked(e, lat_long)) begin
            x_err[s]  = 1'b1;
            x_etag[s] = "R9";
        end else if (v && w) begin
            s0 = (e + 1) % RING;
            s1 = (e + 2) % RING;
            d_en[s0] = 1'b1; d_cap[s0] = 1'b1; d_val[s0] = DW'($urandom); d_idx[s0] = 2 * int'(a);
            d_en[s1] = 1'b1; d_cap[s1] = 1'b1; d_val[s1] = DW'($urandom); d_idx[s1] = 2 * int'(a) + 1;
        end else if (v) begin
            lat  = lat_halves(lat_long);
            rtag = lat_long ? "R3" : "R4";
            if (rd_at[(e + RING - 2) % RING]) rtag = "R6";
            if (tag != "") rtag = tag;
            if (d_cap[s] && d_idx[s] == 2 * int'(a) + 1) rtag = "R7";
            s0 = (e + lat) % RING;
            s1 = (e + lat + 1) % RING;
            x_vld[s0] = 1'b1; x_q[s0] = ref_mem[2 * int'(a)];     x_tag[s0] = rtag;
            x_vld[s1] = 1'b1; x_q[s1] = ref_mem[2 * int'(a) + 1]; x_tag[s1] = rtag;
        end
        @(posedge clk);
        @(negedge clk);
        check(q_vld == x_vld[s], rst_n ? "R5" : "R10", "q_vld", longint'(q_vld), longint'(x_vld[s]));
        if (x_vld[s])
            check(dq === x_q[s], x_tag[s], "read word", longint'(dq), longint'(x_q[s]));
        check(proto_err == x_err[s], x_etag[s], "proto_err", longint'(proto_err), longint'(x_err[s]));
        x_vld[s] = 1'b0;
        x_err[s] = 1'b0;
        d_en[s]  = 1'b0;
        d_cap[s] = 1'b0;
        e++;
    endtask

    // One K period: command on the K edge, idle on the K# edge
    task automatic kcycle(bit v, bit w, logic [AW-1:0] a, string tag);
        edge_cmd(v, w, a, tag);
        edge_cmd(1'b0, 1'b0, '0, "");
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) kcycle(1'b0, 1'b0, '0, "");
    endtask

    task automatic random_run(int n);
        int r;
        for (int i = 0; i < n; i++) begin
            r = int'($urandom % 16);
            if (r < 7)       edge_cmd(1'b1, 1'b0, AW'($urandom), "");
            else if (r < 12) edge_cmd(1'b1, 1'b1, AW'($urandom), "");
            else             edge_cmd(1'b0, 1'b0, '0, "");
            if ($urandom % 12 == 0) edge_cmd(1'b1, 1'($urandom), AW'($urandom), "R1");
            else                    edge_cmd(1'b0, 1'b0, '0, "");
        end
    endtask

    initial begin
        int unused_seed;
        unused_seed = int'($urandom(32'd20240607));
        @(negedge clk);
        // R10: reset state
        for (int i = 0; i < 4; i++) edge_cmd(1'b0, 1'b0, '0, "");
        rst_n = 1'b1;
        // R2: fill every address, then read all back in order (long latency)
        for (int a = 0; a < DEPTH; a++) kcycle(1'b1, 1'b1, AW'(a), "");
        drain();
        for (int a = 0; a < DEPTH; a++) kcycle(1'b1, 1'b0, AW'(a), "R2");
        drain();
        // R7: read one K period after a write to the same address
        kcycle(1'b1, 1'b1, 4'd3, "");
        kcycle(1'b1, 1'b0, 4'd3, "R7");
        drain();
        // R8: read then write the same address; the read keeps the old pair
        kcycle(1'b1, 1'b0, 4'd5, "R8");
        kcycle(1'b1, 1'b1, 4'd5, "");
        drain();
        kcycle(1'b1, 1'b0, 4'd5, "R8");
        drain();
        // R9: write two K periods after a read (long) is dropped
        kcycle(1'b1, 1'b0, 4'd2, "");
        kcycle(1'b0, 1'b0, '0, "");
        kcycle(1'b1, 1'b1, 4'd2, "R9");
        drain();
        kcycle(1'b1, 1'b0, 4'd2, "R9");
        drain();
        // R1: read and write on K# edges are dropped
        edge_cmd(1'b0, 1'b0, '0, "");
        edge_cmd(1'b1, 1'b1, 4'd7, "R1");
        edge_cmd(1'b0, 1'b0, '0, "");
        edge_cmd(1'b1, 1'b0, 4'd7, "R1");
        drain();
        kcycle(1'b1, 1'b0, 4'd7, "R1");
        drain();
        random_run(600);
        drain();
        // R4 / R9: short latency
        lat_long = 1'b0;
        kcycle(1'b1, 1'b0, 4'd9, "R4");
        kcycle(1'b1, 1'b1, 4'd9, "R9");
        drain();
        kcycle(1'b1, 1'b0, 4'd9, "R9");
        drain();
        random_run(600);
        drain();
        lat_long = 1'b1;
        random_run(300);
        drain();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule